// File: doc/BRIEF.md
# Page-Shadow Check-Target Resolver

This block resolves a call-target address into the address of the checking routine that is responsible for that target. A shadow table in memory holds one 16-bit entry for each 4096-byte page of address space. The block takes a target address and forms its page index. It reads the matching shadow entry through an attached read port that has one cycle of latency. It then sorts the entry into one of three classes: invalid, trusted (unchecked) or checked.

For a checked page, the entry holds a distance measured in pages. The routine address is the target rounded up to the next page boundary, minus the entry value plus one, times the page size. An address that already sits on a page boundary is left as it is by the rounding. A requester pulses a request in the idle state and collects the class and the address when the done strobe arrives. The block does not fill the table.

Top module: `page_shadow_resolver`

## Requirements
- R1: After reset, done and mem_rd_en are 0, result_class is 0 (invalid) and check_addr is 0.
- R2: The edge that accepts a request is followed by exactly one cycle with mem_rd_en high. In that cycle mem_rd_addr equals TABLE_BASE + 2*(req_addr >> 12).
- R3: done is high for exactly one cycle. That cycle begins two clock edges after the edge that accepted the request.
- R4: A shadow entry of 0xFFFF gives result_class 1 (trusted) and check_addr 0.
- R5: A shadow entry of 0x0000 gives result_class 0 (invalid) and check_addr 0.
- R6: Any other entry V gives result_class 2 (checked). In that case check_addr = roundup4096(req_addr) - (V+1)*4096, taken modulo 2^ADDR_W, and its low 12 bits are zero.
- R7: When req_addr is already page aligned, the rounding leaves it unchanged. The next byte address rounds to the following page.
- R8: A request raised while a lookup is in flight is ignored. No further read is issued, and the result belongs to the first request.
- R9: result_class and check_addr change only on the cycle that done is high, and they hold their values between results.
- R10: The largest distance code, 0xFFFE, places the routine 65535 pages (just under 256 MB) below the rounded target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, accepted only when idle |
| req_addr | input | ADDR_W | Call-target address |
| mem_rd_en | output | 1 | Shadow table read enable |
| mem_rd_addr | output | ADDR_W | Byte address of the shadow entry |
| mem_rd_data | input | ENTRY_W | Shadow entry, valid one cycle after the read |
| done | output | 1 | One-cycle result strobe |
| result_class | output | 2 | 0 invalid, 1 trusted, 2 checked |
| check_addr | output | ADDR_W | Check-routine address (0 unless checked) |

## Verification
The resolver is driven with three kinds of entry: the two reserved codes, and ordinary distances that include the largest legal code. These show whether the decoding of the reserved codes is kept apart from the distance arithmetic. Two targets that differ only in being page aligned show whether the rounding step is done right. A second request raised during a lookup, and idle cycles after a result, show whether the state machine ignores stray requests and holds its outputs.

// File: rtl/pshadow_pkg.sv
package pshadow_pkg;
   typedef enum logic [1:0] {
      PS_INVALID = 2'd0,
      PS_TRUSTED = 2'd1,
      PS_CHECKED = 2'd2
   } ps_class_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_READ = 2'd1,
      ST_CALC = 2'd2
   } ps_state_e;
endpackage

// File: rtl/shadow_index_gen.sv
module shadow_index_gen #(
   parameter int ADDR_W      = 32,
   parameter int PAGE_SHIFT  = 12,
   parameter int ENTRY_LOG2  = 1,
   parameter logic [ADDR_W-1:0] TABLE_BASE = '0
) (
   input  logic [ADDR_W-1:0] target,
   output logic [ADDR_W-1:0] page_idx,
   output logic [ADDR_W-1:0] table_addr
);
   assign page_idx   = target >> PAGE_SHIFT;
   assign table_addr = TABLE_BASE + (page_idx << ENTRY_LOG2);
endmodule

// File: rtl/shadow_decode.sv
module shadow_decode
   import pshadow_pkg::*;
#(
   parameter int ENTRY_W = 16
) (
   input  logic [ENTRY_W-1:0] entry,
   output ps_class_e          cls,
   output logic [ENTRY_W:0]   dist_pages
);
   localparam logic [ENTRY_W-1:0] CODE_TRUSTED = '1;
   localparam logic [ENTRY_W-1:0] CODE_INVALID = '0;

   always_comb begin
      if (entry == CODE_INVALID)      cls = PS_INVALID;
      else if (entry == CODE_TRUSTED) cls = PS_TRUSTED;
      else                            cls = PS_CHECKED;
   end

   assign dist_pages = {1'b0, entry} + {{ENTRY_W{1'b0}}, 1'b1};
endmodule

// File: rtl/check_target_calc.sv
module check_target_calc #(
   parameter int ADDR_W     = 32,
   parameter int PAGE_SHIFT = 12,
   parameter int ENTRY_W    = 16
) (
   input  logic [ADDR_W-1:0]  target,
   input  logic [ENTRY_W:0]   dist_pages,
   output logic [ADDR_W-1:0]  routine_addr
);
   localparam int OFF_W = ENTRY_W + 1 + PAGE_SHIFT;
   localparam logic [ADDR_W-1:0] PAGE_MASK = (ADDR_W'(1) << PAGE_SHIFT) - ADDR_W'(1);

   logic [OFF_W-1:0]  off_full;
   logic [ADDR_W-1:0] off;
   logic [ADDR_W-1:0] aligned;

   assign off_full = {dist_pages, {PAGE_SHIFT{1'b0}}};

   generate
      if (OFF_W < ADDR_W) begin : g_widen
         assign off = {{(ADDR_W-OFF_W){1'b0}}, off_full};
      end else begin : g_trunc
         assign off = off_full[ADDR_W-1:0];
      end
   endgenerate

   assign aligned      = (target + PAGE_MASK) & ~PAGE_MASK;
   assign routine_addr = aligned - off;
endmodule

// File: rtl/page_shadow_resolver.sv
module page_shadow_resolver
   import pshadow_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int PAGE_SHIFT = 12,
   parameter int ENTRY_W    = 16,
   parameter logic [ADDR_W-1:0] TABLE_BASE = 32'h4000_0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              mem_rd_en,
   output logic [ADDR_W-1:0] mem_rd_addr,
   input  logic [ENTRY_W-1:0] mem_rd_data,
   output logic              done,
   output logic [1:0]        result_class,
   output logic [ADDR_W-1:0] check_addr
);
   localparam int ENTRY_LOG2 = $clog2(ENTRY_W / 8);

   generate
      if (PAGE_SHIFT < 1 || PAGE_SHIFT >= ADDR_W) begin : g_bad_page
         $error("PAGE_SHIFT out of range");
      end
      if (ENTRY_W % 8 != 0 || ENTRY_W < 8) begin : g_bad_entry
         $error("ENTRY_W must be a whole number of bytes");
      end
   endgenerate

   ps_state_e         state_q;
   logic [ADDR_W-1:0] target_q;
   logic [ADDR_W-1:0] rd_addr_q;
   logic [ADDR_W-1:0] page_idx;
   logic [ADDR_W-1:0] tbl_addr;
   ps_class_e         dec_cls;
   logic [ENTRY_W:0]  dist_pages;
   logic [ADDR_W-1:0] routine;

   shadow_index_gen #(
      .ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT),
      .ENTRY_LOG2(ENTRY_LOG2), .TABLE_BASE(TABLE_BASE)
   ) u_idx (
      .target(req_addr), .page_idx(page_idx), .table_addr(tbl_addr)
   );

   shadow_decode #(.ENTRY_W(ENTRY_W)) u_dec (
      .entry(mem_rd_data), .cls(dec_cls), .dist_pages(dist_pages)
   );

   check_target_calc #(
      .ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT), .ENTRY_W(ENTRY_W)
   ) u_calc (
      .target(target_q), .dist_pages(dist_pages), .routine_addr(routine)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q      <= ST_IDLE;
         target_q     <= '0;
         rd_addr_q    <= '0;
         done         <= 1'b0;
         result_class <= PS_INVALID;
         check_addr   <= '0;
      end else begin
         done <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (req_valid) begin
                  target_q  <= req_addr;
                  rd_addr_q <= tbl_addr;
                  state_q   <= ST_READ;
               end
            end
            ST_READ: state_q <= ST_CALC;
            ST_CALC: begin
               result_class <= dec_cls;
               check_addr   <= (dec_cls == PS_CHECKED) ? routine : '0;
               done         <= 1'b1;
               state_q      <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign mem_rd_en   = (state_q == ST_READ);
   assign mem_rd_addr = rd_addr_q;

   logic unused_ok;
   assign unused_ok = ^page_idx;
endmodule

// File: rtl/pshadow_checker.sv
module pshadow_checker #(
   parameter int ADDR_W  = 32,
   parameter int ENTRY_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mem_rd_en,
   input logic [ENTRY_W-1:0] mem_rd_data,
   input logic              done,
   input logic [1:0]        result_class,
   input logic [ADDR_W-1:0] check_addr
);
   assert_rd_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_en |=> !mem_rd_en);

   assert_done_timing_R3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_en |-> ##2 done);

   assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_trusted_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (done && $past(mem_rd_data) == '1) |-> (result_class == 2'd1 && check_addr == '0));

   assert_invalid_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (done && $past(mem_rd_data) == '0) |-> (result_class == 2'd0 && check_addr == '0));

   assert_checked_aligned_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (done && result_class == 2'd2) |-> (check_addr[11:0] == 12'h000));

   assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(check_addr) || !$stable(result_class)) |-> done);
endmodule

bind page_shadow_resolver pshadow_checker #(.ADDR_W(ADDR_W), .ENTRY_W(ENTRY_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .mem_rd_en(mem_rd_en), .mem_rd_data(mem_rd_data),
   .done(done), .result_class(result_class), .check_addr(check_addr)
);

// File: tb/tb_page_shadow_resolver.sv
module tb_page_shadow_resolver;
   localparam logic [31:0] BASE = 32'h4000_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] req_addr = '0;
   logic        mem_rd_en;
   logic [31:0] mem_rd_addr;
   logic [15:0] mem_rd_data = '0;
   logic        done;
   logic [1:0]  result_class;
   logic [31:0] check_addr;

   int tests = 0;
   int fails = 0;
   int rd_cnt = 0;
   bit finished = 0;
   logic [15:0] shadow [0:255];

   always #5 clk = ~clk;

   page_shadow_resolver #(.TABLE_BASE(BASE)) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
      .done(done), .result_class(result_class), .check_addr(check_addr)
   );

   always_ff @(posedge clk) begin
      if (mem_rd_en) begin
         mem_rd_data <= shadow[8'((mem_rd_addr - BASE) >> 1)];
         rd_cnt      <= rd_cnt + 1;
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] model_addr(input logic [31:0] a, input logic [15:0] v);
      logic [31:0] up;
      up = (a + 32'h0000_0FFF) & 32'hFFFF_F000;
      return up - (({16'h0, v} + 32'd1) << 12);
   endfunction

   function automatic logic [1:0] model_cls(input logic [15:0] v);
      if (v == 16'h0000) return 2'd0;
      if (v == 16'hFFFF) return 2'd1;
      return 2'd2;
   endfunction

   task automatic lookup(input logic [31:0] a, input logic [15:0] v, input string tag);
      logic [31:0] exp_a;
      int rd0;
      shadow[8'(a >> 12)] = v;
      exp_a = (model_cls(v) == 2'd2) ? model_addr(a, v) : 32'h0;
      rd0 = rd_cnt;
      @(negedge clk); req_valid = 1'b1; req_addr = a;
      @(negedge clk); req_valid = 1'b0;
      chk(mem_rd_en == 1'b1, {tag, " R2 rd_en"}, 32'(mem_rd_en), 32'd1);
      chk(mem_rd_addr == BASE + ((a >> 12) << 1), {tag, " R2 rd_addr"}, mem_rd_addr, BASE + ((a >> 12) << 1));
      @(negedge clk);
      chk(mem_rd_en == 1'b0 && done == 1'b0, {tag, " R2/R3 gap"}, {30'h0, mem_rd_en, done}, 32'h0);
      @(negedge clk);
      chk(done == 1'b1, {tag, " R3 done"}, 32'(done), 32'd1);
      chk(result_class == model_cls(v), {tag, " class"}, 32'(result_class), 32'(model_cls(v)));
      chk(check_addr == exp_a, {tag, " addr"}, check_addr, exp_a);
      chk(rd_cnt - rd0 == 1, {tag, " R2 one read"}, 32'(rd_cnt - rd0), 32'd1);
      @(negedge clk);
      chk(done == 1'b0, {tag, " R3 pulse"}, 32'(done), 32'd0);
   endtask

   task automatic test_reset();
      chk(done == 0 && mem_rd_en == 0, "R1 strobes", {30'h0, done, mem_rd_en}, 32'h0);
      chk(result_class == 2'd0, "R1 class", 32'(result_class), 32'd0);
      chk(check_addr == 32'h0, "R1 addr", check_addr, 32'h0);
   endtask

   task automatic test_busy();
      int rd0;
      shadow[8'h45] = 16'h0003;
      shadow[8'h77] = 16'hFFFF;
      rd0 = rd_cnt;
      @(negedge clk); req_valid = 1'b1; req_addr = 32'h0004_5123;
      @(negedge clk); req_addr = 32'h0007_7000;
      @(negedge clk); req_valid = 1'b0;
      @(negedge clk);
      chk(done == 1'b1, "R8 done", 32'(done), 32'd1);
      chk(result_class == 2'd2, "R8 class first", 32'(result_class), 32'd2);
      chk(check_addr == model_addr(32'h0004_5123, 16'h0003), "R8 addr first", check_addr, model_addr(32'h0004_5123, 16'h0003));
      chk(rd_cnt - rd0 == 1, "R8 single read", 32'(rd_cnt - rd0), 32'd1);
      @(negedge clk);
   endtask

   task automatic test_hold();
      logic [31:0] a0;
      logic [1:0]  c0;
      lookup(32'h0003_4567, 16'h0002, "R9 setup");
      a0 = check_addr; c0 = result_class;
      repeat (4) @(negedge clk);
      chk(check_addr == a0 && check_addr == 32'h0003_2000, "R9 addr held", check_addr, 32'h0003_2000);
      chk(result_class == c0, "R9 class held", 32'(result_class), 32'(c0));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         fails++;
         tests++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 256; i++) shadow[i] = 16'h0;
      repeat (3) @(negedge clk);
      test_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      lookup(32'h0001_2345, 16'hFFFF, "R4 trusted");
      lookup(32'h0000_5010, 16'h0000, "R5 invalid");
      lookup(32'h0003_4567, 16'h0002, "R6 checked");
      lookup(32'h0003_6000, 16'h0001, "R7 aligned");
      chk(check_addr == 32'h0003_4000, "R7 aligned value", check_addr, 32'h0003_4000);
      lookup(32'h0003_6001, 16'h0001, "R7 unaligned");
      chk(check_addr == 32'h0003_5000, "R7 unaligned value", check_addr, 32'h0003_5000);
      lookup(32'h1000_0800, 16'hFFFE, "R10 max distance");
      chk(check_addr == 32'h0000_2000, "R10 value", check_addr, 32'h0000_2000);
      test_busy();
      test_hold();
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule